// File: doc/BRIEF.md
# Routed State-Variable Filter Core

This block is the arithmetic heart of a three-voice synthesizer filter. Each accepted input beat carries three signed 20-bit voice samples. Each voice is scaled down, and a 3-bit routing mask then sends every voice either into a two-integrator-loop (state-variable) filter or around it. The core keeps the highpass, bandpass and lowpass integrator states and the sum of the voices that bypass the filter, all as signed fixed-point integers. Each accepted beat advances the filter by exactly one step. The cutoff coefficient and the inverse-resonance coefficient come in as plain control inputs. Mapping the cutoff frequency to a coefficient, decoding register writes and mixing the final output are all done elsewhere.

The sample stream uses a valid/ready handshake. `in_ready` is low during reset and high from the first clock edge after reset. The core never applies back-pressure after that point, because it finishes one step per cycle. A step happens on every rising edge where `in_valid` and `in_ready` are both high. The four result registers update on that edge, and `out_valid` is high for the cycle that follows it. The output side has no ready: a downstream stage that wants to keep a result must capture it while `out_valid` is high, because the registers hold only until the next accepted beat.

A filter-enable control turns the core into a plain mixer. A voice-3 mute control silences the third voice only while that voice bypasses the filter.

Top module: `svf_route_core`

## Requirements
- R1: While `rst` is high and on the edge that samples it, `hp_out`, `bp_out`, `lp_out` and `byp_out` become 0, and `out_valid` and `in_ready` are low. `in_ready` is high from the first edge after `rst` falls.
- R2: Before any summing, each voice is arithmetic-shifted right by 7 bits and sign-extended, so a voice of -1 becomes -1, -128 becomes -1 and -129 becomes -2.
- R3: Routing bit 0 selects voice 1, bit 1 selects voice 2 and bit 2 selects voice 3. The selected scaled voices add up to the filter input vi. The unselected ones add up to the value stored in `byp_out`.
- R4: With routing mask 0, vi is 0, so from an all-zero state every filter state stays 0. With routing mask 7 and the filter enabled, `byp_out` becomes 0.
- R5: When `v3_mute` is high and routing bit 2 is 0, voice 3 counts as 0. When routing bit 2 is 1, voice 3 is never muted. This rule applies whether the filter is enabled or not.
- R6: On an accepted beat with `flt_en` low, `byp_out` becomes the sum of all three scaled voices (voice 3 subject to R5), and `hp_out`, `bp_out` and `lp_out` become 0.
- R7: On an accepted beat with `flt_en` high, first compute dbp = (w0*hp)>>>20 and dlp = (w0*bp)>>>20 from the old states. The new bp is bp-dbp and the new lp is lp-dlp. `w0` is unsigned.
- R8: After the R7 update, the new hp is ((new bp * invq)>>>10) - new lp - vi. `invq` is unsigned and equals 1024/Q. All arithmetic is signed and wraps at 32 bits, with no saturation.
- R9: On an edge without an accepted beat, all four result registers keep their values.
- R10: `out_valid` is high exactly in the cycle after an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Voice beat present |
| in_ready | output | 1 | Core accepts a beat |
| voice1 | input | 20 | Voice 1 sample, signed |
| voice2 | input | 20 | Voice 2 sample, signed |
| voice3 | input | 20 | Voice 3 sample, signed |
| route | input | 3 | Routing mask, one bit per voice |
| v3_mute | input | 1 | Mute voice 3 when it bypasses the filter |
| flt_en | input | 1 | Filter enable; low bypasses all voices and clears the filter state |
| w0 | input | 16 | Cutoff coefficient, unsigned |
| invq | input | 16 | Inverse-resonance coefficient (1024/Q), unsigned |
| out_valid | output | 1 | Results updated on the previous edge |
| hp_out | output | 32 | Highpass state, signed |
| bp_out | output | 32 | Bandpass state, signed |
| lp_out | output | 32 | Lowpass state, signed |
| byp_out | output | 32 | Bypass sum, signed |

## Verification
The voice-3 mute rule and the filter-disable mode can act on the same beat. In that case routing bit 2 still decides whether voice 3 joins the bypass sum, even though nothing goes into the filter. The random stream toggles `v3_mute`, `flt_en` and the routing mask independently on each beat, and directed beats set all three together. For every such beat, the `byp_out` value and the cleared filter states are compared with a reference model built from the requirement formulas. A second coincidence is an accepted beat with mask 7 while the states are non-zero. That beat is judged on `byp_out` reaching zero while the integrators keep evolving.

// File: rtl/svf_pkg.sv
package svf_pkg;
  localparam int NUM_VOICES  = 3;
  localparam int DEF_VOICE_W = 20;
  localparam int DEF_SCALE   = 7;
  localparam int DEF_STATE_W = 32;
  localparam int DEF_COEF_W  = 16;
  localparam int DEF_PROD_W  = 48;
  localparam int DEF_W0_SH   = 20;
  localparam int DEF_Q_SH    = 10;

  typedef enum logic [1:0] {
    STEP_NONE   = 2'd0,
    STEP_FILTER = 2'd1,
    STEP_BYPASS = 2'd2
  } step_kind_e;
endpackage

// File: rtl/svf_voice_scale.sv
module svf_voice_scale #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 32,
  parameter int SHIFT = 7
) (
  input  logic [IN_W-1:0]         din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int KEPT = IN_W - SHIFT;

  logic signed [KEPT-1:0] kept;

  always_comb begin
    kept = din[IN_W-1:SHIFT];
    dout = {{(OUT_W-KEPT){kept[KEPT-1]}}, kept};
  end
endmodule

// File: rtl/svf_router.sv
module svf_router #(
  parameter int VOICE_W = 20,
  parameter int SHIFT   = 7,
  parameter int SUM_W   = 32
) (
  input  logic [svf_pkg::NUM_VOICES*VOICE_W-1:0] voices,
  input  logic [svf_pkg::NUM_VOICES-1:0]         route,
  input  logic                                   v3_mute,
  input  logic                                   flt_en,
  output logic signed [SUM_W-1:0]                vi,
  output logic signed [SUM_W-1:0]                byp_next
);
  localparam int NV = svf_pkg::NUM_VOICES;
  localparam int V3 = NV - 1;

  logic signed [SUM_W-1:0] scaled [NV];
  logic signed [SUM_W-1:0] eff    [NV];
  logic                    v3_silenced;

  genvar gi;
  generate
    for (gi = 0; gi < NV; gi++) begin : g_scale
      svf_voice_scale #(
        .IN_W (VOICE_W),
        .OUT_W(SUM_W),
        .SHIFT(SHIFT)
      ) u_scale (
        .din (voices[gi*VOICE_W +: VOICE_W]),
        .dout(scaled[gi])
      );
    end
  endgenerate

  // Muting of the last voice only applies while it bypasses the filter.
  assign v3_silenced = v3_mute && !route[V3];

  always_comb begin
    for (int i = 0; i < NV; i++) begin
      eff[i] = scaled[i];
    end
    if (v3_silenced) begin
      eff[V3] = '0;
    end
  end

  always_comb begin
    vi       = '0;
    byp_next = '0;
    for (int i = 0; i < NV; i++) begin
      if (flt_en && route[i]) begin
        vi = vi + eff[i];
      end else begin
        byp_next = byp_next + eff[i];
      end
    end
    if (!flt_en) begin
      vi = '0;
    end
  end

  // R4: an empty mask feeds nothing into the filter
  always_comb begin
    a_r4_empty_mask: assert (!(route == '0) || vi == '0);
  end
endmodule

// File: rtl/svf_integrator.sv
module svf_integrator #(
  parameter int STATE_W = 32,
  parameter int COEF_W  = 16,
  parameter int PROD_W  = 48,
  parameter int W0_SH   = 20,
  parameter int Q_SH    = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic                      flt_en,
  input  logic [COEF_W-1:0]         w0,
  input  logic [COEF_W-1:0]         invq,
  input  logic signed [STATE_W-1:0] vi,
  output logic signed [STATE_W-1:0] hp,
  output logic signed [STATE_W-1:0] bp,
  output logic signed [STATE_W-1:0] lp
);
  localparam int SX = PROD_W - STATE_W;
  localparam int CX = PROD_W - COEF_W;

  svf_pkg::step_kind_e kind;

  logic signed [PROD_W-1:0]  w0_x, invq_x;
  logic signed [PROD_W-1:0]  hp_x, bp_x, bpn_x;
  logic signed [PROD_W-1:0]  p_bp, p_lp, p_q;
  logic signed [PROD_W-1:0]  s_bp, s_lp, s_q;
  logic signed [STATE_W-1:0] d_bp, d_lp, q_term;
  logic signed [STATE_W-1:0] bp_n, lp_n, hp_n;

  always_comb begin
    if (!step)        kind = svf_pkg::STEP_NONE;
    else if (!flt_en) kind = svf_pkg::STEP_BYPASS;
    else              kind = svf_pkg::STEP_FILTER;
  end

  // Integrator deltas use the old states; hp then uses the new bp and lp.
  always_comb begin
    w0_x   = {{CX{1'b0}}, w0};
    invq_x = {{CX{1'b0}}, invq};
    hp_x   = {{SX{hp[STATE_W-1]}}, hp};
    bp_x   = {{SX{bp[STATE_W-1]}}, bp};
    p_bp   = w0_x * hp_x;
    p_lp   = w0_x * bp_x;
    s_bp   = p_bp >>> W0_SH;
    s_lp   = p_lp >>> W0_SH;
    d_bp   = s_bp[STATE_W-1:0];
    d_lp   = s_lp[STATE_W-1:0];
    bp_n   = bp - d_bp;
    lp_n   = lp - d_lp;
    bpn_x  = {{SX{bp_n[STATE_W-1]}}, bp_n};
    p_q    = bpn_x * invq_x;
    s_q    = p_q >>> Q_SH;
    q_term = s_q[STATE_W-1:0];
    hp_n   = q_term - lp_n - vi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hp <= '0;
      bp <= '0;
      lp <= '0;
    end else begin
      unique case (kind)
        svf_pkg::STEP_FILTER: begin
          hp <= hp_n;
          bp <= bp_n;
          lp <= lp_n;
        end
        svf_pkg::STEP_BYPASS: begin
          hp <= '0;
          bp <= '0;
          lp <= '0;
        end
        default: ;
      endcase
    end
  end

  // R6: a disabled step leaves all three integrator states at zero
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (step && !flt_en) |=> (hp == '0 && bp == '0 && lp == '0));

  // R7: with a zero cutoff coefficient the integrators do not move
  a_r7_zero_cutoff_holds: assert property (@(posedge clk) disable iff (rst)
    (step && flt_en && w0 == '0) |=> ($stable(bp) && $stable(lp)));
endmodule

// File: rtl/svf_route_core.sv
module svf_route_core #(
  parameter int VOICE_W = svf_pkg::DEF_VOICE_W,
  parameter int SCALE   = svf_pkg::DEF_SCALE,
  parameter int STATE_W = svf_pkg::DEF_STATE_W,
  parameter int COEF_W  = svf_pkg::DEF_COEF_W,
  parameter int PROD_W  = svf_pkg::DEF_PROD_W,
  parameter int W0_SH   = svf_pkg::DEF_W0_SH,
  parameter int Q_SH    = svf_pkg::DEF_Q_SH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [VOICE_W-1:0]        voice1,
  input  logic [VOICE_W-1:0]        voice2,
  input  logic [VOICE_W-1:0]        voice3,
  input  logic [2:0]                route,
  input  logic                      v3_mute,
  input  logic                      flt_en,
  input  logic [COEF_W-1:0]         w0,
  input  logic [COEF_W-1:0]         invq,
  output logic                      out_valid,
  output logic signed [STATE_W-1:0] hp_out,
  output logic signed [STATE_W-1:0] bp_out,
  output logic signed [STATE_W-1:0] lp_out,
  output logic signed [STATE_W-1:0] byp_out
);
  logic                      step;
  logic signed [STATE_W-1:0] vi;
  logic signed [STATE_W-1:0] byp_next;

  assign step = in_valid && in_ready;

  svf_router #(
    .VOICE_W(VOICE_W),
    .SHIFT  (SCALE),
    .SUM_W  (STATE_W)
  ) u_router (
    .voices  ({voice3, voice2, voice1}),
    .route   (route),
    .v3_mute (v3_mute),
    .flt_en  (flt_en),
    .vi      (vi),
    .byp_next(byp_next)
  );

  svf_integrator #(
    .STATE_W(STATE_W),
    .COEF_W (COEF_W),
    .PROD_W (PROD_W),
    .W0_SH  (W0_SH),
    .Q_SH   (Q_SH)
  ) u_integ (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .flt_en(flt_en),
    .w0    (w0),
    .invq  (invq),
    .vi    (vi),
    .hp    (hp_out),
    .bp    (bp_out),
    .lp    (lp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      byp_out   <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= step;
      if (step) begin
        byp_out <= byp_next;
      end
    end
  end

  // R9: without an accepted beat nothing moves
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(hp_out) && $stable(bp_out) && $stable(lp_out) && $stable(byp_out)));

  // R10: out_valid follows an accepted beat by one cycle
  a_r10_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    step |=> out_valid);
  a_r10_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> !out_valid);

  // R4: a full mask leaves nothing in the bypass sum
  a_r4_full_mask: assert property (@(posedge clk) disable iff (rst)
    (step && flt_en && route == 3'b111) |=> (byp_out == '0));

  // R1: the core is never ready while reset is applied
  a_r1_not_ready: assert property (@(posedge clk)
    rst |=> !in_ready && !out_valid);
endmodule

// File: tb/svf_route_core_bench.sv
module svf_route_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] voice1 = '0, voice2 = '0, voice3 = '0;
  logic [2:0]  route = '0;
  logic        v3_mute = 1'b0;
  logic        flt_en = 1'b1;
  logic [15:0] w0 = '0, invq = '0;
  logic        out_valid;
  logic signed [31:0] hp_out, bp_out, lp_out, byp_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_hp = 0, m_bp = 0, m_lp = 0, m_byp = 0;
  bit m_valid = 0;

  always #2 clk = ~clk;

  svf_route_core u_svf_route_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .voice1(voice1), .voice2(voice2), .voice3(voice3), .route(route),
    .v3_mute(v3_mute), .flt_en(flt_en), .w0(w0), .invq(invq),
    .out_valid(out_valid), .hp_out(hp_out), .bp_out(bp_out),
    .lp_out(lp_out), .byp_out(byp_out)
  );

  function automatic int scale7(logic [19:0] v);
    int s;
    s = int'($signed(v));
    return s >>> 7;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference step, built from R2..R8
  task automatic model_step();
    int v[3];
    int vi_s, byp_s;
    int dbp, dlp;
    v[0] = scale7(voice1);
    v[1] = scale7(voice2);
    v[2] = scale7(voice3);
    if (v3_mute && !route[2]) v[2] = 0;
    if (!flt_en) begin
      m_byp = v[0] + v[1] + v[2];
      m_hp = 0; m_bp = 0; m_lp = 0;
    end else begin
      vi_s = 0; byp_s = 0;
      for (int i = 0; i < 3; i++) begin
        if (route[i]) vi_s += v[i];
        else          byp_s += v[i];
      end
      dbp = int'((longint'(m_hp) * longint'(w0)) >>> 20);
      dlp = int'((longint'(m_bp) * longint'(w0)) >>> 20);
      m_bp = m_bp - dbp;
      m_lp = m_lp - dlp;
      m_hp = int'((longint'(m_bp) * longint'(invq)) >>> 10) - m_lp - vi_s;
      m_byp = byp_s;
    end
  endtask

  task automatic beat(string tag, bit vld);
    in_valid = vld;
    @(posedge clk);
    if (vld) model_step();
    m_valid = vld;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "hp", hp_out, m_hp);
    chk(tag, "bp", bp_out, m_bp);
    chk(tag, "lp", lp_out, m_lp);
    chk(tag, "byp", byp_out, m_byp);
    chk(tag, "out_valid", out_valid, m_valid);
  endtask

  task automatic set_v(int a, int b, int c);
    voice1 = 20'(a); voice2 = 20'(b); voice3 = 20'(c);
  endtask

  initial begin
    void'($urandom(32'h5EED_0F17));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "in_ready", in_ready, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "byp", byp_out, 0);
    chk("R1", "hp", hp_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", in_ready, 1);

    // R2: scaling of negative values, filter off so byp shows the sum
    flt_en = 1'b0;
    set_v(-1, 0, 0);    beat("R2", 1);
    chk("R2", "-1 scaled", byp_out, -1);
    set_v(-128, 0, 0);  beat("R2", 1);
    chk("R2", "-128 scaled", byp_out, -1);
    set_v(-129, 0, 0);  beat("R2", 1);
    chk("R2", "-129 scaled", byp_out, -2);
    set_v(1280, 256, 0); beat("R2", 1);
    chk("R2", "positive sum", byp_out, 12);

    // R5 with R6: mute while disabled, bit 2 clear then set
    set_v(1280, 1280, 1280); v3_mute = 1'b1; route = 3'b000;
    beat("R5", 1);
    chk("R5", "muted v3 bypass", byp_out, 20);
    route = 3'b100; beat("R5", 1);
    chk("R6", "disabled keeps routed v3", byp_out, 30);
    chk("R6", "hp cleared", hp_out, 0);

    // R4: empty mask keeps state at zero
    flt_en = 1'b1; route = 3'b000; w0 = 16'd9000; invq = 16'd1024;
    beat("R4", 1);
    chk("R4", "empty mask hp", hp_out, 0);
    // R5 + R8: routed v3 with mute set goes into filter, hp = -vi
    route = 3'b100; beat("R5", 1);
    chk("R5", "routed v3 not muted byp", byp_out, 20);
    chk("R8", "hp from vi", hp_out, -10);
    // R3/R4: full mask
    route = 3'b111; beat("R4", 1);
    chk("R4", "full mask byp", byp_out, 0);
    // R3: single-voice masks
    route = 3'b010; set_v(256, 512, 768); v3_mute = 1'b0; beat("R3", 1);
    chk("R3", "mask 2 byp", byp_out, 8);
    // R9: idle beats leave state
    beat("R9", 0);
    beat("R9", 0);
    // R7: zero cutoff, integrators hold
    w0 = 16'd0; beat("R7", 1);
    // R6: disable clears a live state
    flt_en = 1'b0; beat("R6", 1);
    chk("R6", "lp cleared", lp_out, 0);

    // Random stream covering R3, R5, R6, R7, R8, R9, R10
    flt_en = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      voice1 = 20'($urandom); voice2 = 20'($urandom); voice3 = 20'($urandom);
      route = 3'($urandom);
      v3_mute = 1'($urandom);
      flt_en = ($urandom_range(0, 15) != 0);
      w0 = 16'($urandom_range(0, 30000));
      invq = 16'($urandom_range(0, 2047));
      beat("R8", ($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule